// File: doc/BRIEF.md
# Programmable 14-bit I/O-Mapped Interval Timer

This block is a countdown timer that sits on a small byte-wide I/O bus with a 3-bit address, write data, read data and separate read and write strobes. Software writes a 14-bit count length and a 2-bit output mode through two byte registers. It then starts the counter with a command bit. The counter steps down once for each rising edge seen on the `count_in` pin. When it finishes a period, it drives `timer_out` as either a square wave or a short low pulse, and it raises a timer flag.

The timer flag is bit 6 of a status byte, which also shows six port handshake bits passed in from outside the block. Reading that status byte clears the flag. Software can read back the live count and the mode of the running count at any time. Changing the length registers has no effect on a count already in progress. The new values are taken only at the next start command.

All pins are plain control and status pins. Data moves through single-cycle strobes with no valid/ready handshake and no back-pressure: `bus_rdata` is combinational and is valid during the cycle `bus_rd` is high, and a write takes effect at the clock edge where `bus_wr` is high.

Top module: `tmr14_top`

## Requirements
- R1: After reset `timer_out` is 1, `timer_irq` is 0, the counter is stopped and reads 0, and the latched mode reads 00.
- R2: A write to address 4 sets length bits 7:0. A write to address 5 sets length bits 13:8 from data bits 5:0 and the mode from data bits 7:6. Neither write alters the count or the latched mode of a running count.
- R3: A write to address 0 with data bit 0 set is a start. It loads the counter with the length, where a length below 2 loads as 2, latches the mode and runs the counter. A write to address 0 with data bit 1 set is a stop and wins over a start. A stop halts the counter and holds its value.
- R4: A running counter decrements once per rising edge of `count_in`, sampled on `clk`. A level held high counts only once. Reading address 4 returns count bits 7:0. Reading address 5 returns {latched mode, count bits 13:8}.
- R5: Terminal count is a count edge while the counter holds 1. In the continuous modes (mode bit 0 = 1) the counter reloads the latched length. In the single modes it goes to 0 and stops. A start or stop in the same cycle overrides the count edge.
- R6: In the square-wave modes (mode bit 1 = 0), a running timer drives `timer_out` high while count > floor(length/2) and low otherwise. An odd length therefore gives a high half one count longer than the low half.
- R7: In the pulse modes (mode bit 1 = 1), a running timer drives `timer_out` low only while the count is 1. A stopped timer always drives `timer_out` high.
- R8: Reading address 0 returns {0, timer flag, port_flags[5:0]}. The flag (also on `timer_irq`) sets at terminal count and clears after a read of address 0. A terminal count in the same cycle as the read wins.
- R9: Addresses 1, 2, 3, 6 and 7 read as 0, and `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, combinational |
| port_flags | input | 6 | Port handshake bits shown in status bits 5:0 |
| count_in | input | 1 | Count pulse input |
| timer_out | output | 1 | Square-wave or pulse output |
| timer_irq | output | 1 | Timer flag |

## Verification
The bench exercises all four output modes, each with its own length:
- an odd length in single square-wave mode, which separates the unequal high and low halves;
- a short even length in continuous pulse mode, which separates reload from stop;
- length 0 and length 1, which expose the floor of 2;
- a `count_in` level held over several clocks, which separates edge counting from level counting.

Length writes and status reads land in the middle of a running count. These show that a rewrite does not disturb the count and that a status read clears only the flag. Every clock, `timer_out`, `timer_irq` and any read data are compared against the bench's behavioural model.

// File: rtl/tmr14_pkg.sv
package tmr14_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_STAT   = 3'd0,
    A_LEN_LO = 3'd4,
    A_LEN_HI = 3'd5
  } reg_addr_e;
  typedef struct packed {
    logic pulse;
    logic cont;
  } omode_t;
endpackage

// File: rtl/tmr14_core.sv
module tmr14_core
  import tmr14_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_in,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] len,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       run_mode,
  output logic             tc,
  output logic             tmr_out
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             tin_q, step, running;
  logic [CNT_W-1:0] rlen, load_val, half;
  omode_t           rmode;

  assign step     = count_in & ~tin_q;
  assign load_val = (len < MIN_LEN) ? MIN_LEN : len;
  assign half     = rlen >> 1;
  assign tc       = running && !stop && !start && step && (cnt == ONE);
  assign run_mode = rmode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tin_q   <= 1'b0;
      cnt     <= '0;
      rlen    <= '0;
      rmode   <= '0;
      running <= 1'b0;
    end else begin
      tin_q <= count_in;
      if (stop) begin
        running <= 1'b0;
      end else if (start) begin
        cnt     <= load_val;
        rlen    <= load_val;
        rmode   <= omode_t'(mode);
        running <= 1'b1;
      end else if (running && step) begin
        if (cnt == ONE) begin
          if (rmode.cont) cnt <= rlen;
          else begin
            cnt     <= '0;
            running <= 1'b0;
          end
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  always_comb begin
    if (!running)        tmr_out = 1'b1;
    else if (rmode.pulse) tmr_out = (cnt != ONE);
    else                 tmr_out = (cnt > half);
  end

  AST_RUN_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt != '0 && cnt <= rlen)); // R5
  AST_LOAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (running && cnt >= MIN_LEN)); // R3
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !rmode.cont) |=> (!running && cnt == '0)); // R5
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |=> $stable(cnt)); // R2
  AST_RELOAD_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && rmode.cont) |=> (running && cnt == $past(rlen))); // R5
endmodule

// File: rtl/tmr14_bus.sv
module tmr14_bus
  import tmr14_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-3:0] port_flags,
  input  logic              tc,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        run_mode,
  output logic [CNT_W-1:0]  len,
  output logic [1:0]        mode,
  output logic              start,
  output logic              stop,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = CNT_W - DATA_W;

  logic stat_rd;
  assign stat_rd = rd && (addr == A_STAT);
  assign start   = wr && (addr == A_STAT) && wdata[0];
  assign stop    = wr && (addr == A_STAT) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len  <= '0;
      mode <= '0;
      flag <= 1'b0;
    end else begin
      if (wr && addr == A_LEN_LO) len[DATA_W-1:0] <= wdata;
      if (wr && addr == A_LEN_HI) begin
        len[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        mode                <= wdata[DATA_W-1:DATA_W-2];
      end
      if (tc)           flag <= 1'b1;
      else if (stat_rd) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        A_STAT:   rdata = {1'b0, flag, port_flags};
        A_LEN_LO: rdata = cnt[DATA_W-1:0];
        A_LEN_HI: rdata = {run_mode, cnt[CNT_W-1:DATA_W]};
        default:  rdata = '0;
      endcase
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> flag); // R8
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tc) |=> !flag); // R8
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)); // R9
endmodule

// File: rtl/tmr14_top.sv
module tmr14_top
  import tmr14_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-3:0] port_flags,
  input  logic              count_in,
  output logic              timer_out,
  output logic              timer_irq
);
  logic [CNT_W-1:0] len, cnt;
  logic [1:0]       mode, run_mode;
  logic             start, stop, tc;

  tmr14_bus #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .rd(bus_rd), .wr(bus_wr), .port_flags(port_flags), .tc(tc),
    .cnt(cnt), .run_mode(run_mode), .len(len), .mode(mode),
    .start(start), .stop(stop), .flag(timer_irq), .rdata(bus_rdata)
  );

  tmr14_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .start(start),
    .stop(stop), .len(len), .mode(mode), .cnt(cnt), .run_mode(run_mode),
    .tc(tc), .tmr_out(timer_out)
  );
endmodule

// File: tb/sim_tmr14_top.sv
module sim_tmr14_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rd = 1'b0, wr = 1'b0, tin = 1'b0;
  logic [5:0] pf = 6'h2A;
  logic [7:0] rdata;
  logic       tout, tirq;
  int errors = 0, checks = 0;

  tmr14_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_wr(wr), .bus_rdata(rdata), .port_flags(pf),
    .count_in(tin), .timer_out(tout), .timer_irq(tirq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  int m_len, m_mode, m_cnt, m_rlen, m_rmode;
  bit m_run, m_flag, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 0; m_mode = 0; m_cnt = 0; m_rlen = 0; m_rmode = 0;
      m_run = 0; m_flag = 0; m_prev = 0;
    end else begin
      bit edge_s, tcf;
      edge_s = tin && !m_prev;
      m_prev = tin;
      tcf = 0;
      if (wr && addr == 0 && wdata[1]) m_run = 0;
      else if (wr && addr == 0 && wdata[0]) begin
        m_rlen = (m_len < 2) ? 2 : m_len;
        m_rmode = m_mode; m_cnt = m_rlen; m_run = 1;
      end else if (m_run && edge_s) begin
        if (m_cnt == 1) begin
          tcf = 1;
          if (m_rmode % 2 == 1) m_cnt = m_rlen;
          else begin m_cnt = 0; m_run = 0; end
        end else m_cnt = m_cnt - 1;
      end
      if (wr && addr == 4) m_len = (m_len & 16'h3F00) | int'(wdata);
      if (wr && addr == 5) begin
        m_len = (m_len & 8'hFF) | (int'(wdata[5:0]) << 8);
        m_mode = int'(wdata[7:6]);
      end
      if (tcf) m_flag = 1;
      else if (rd && addr == 0) m_flag = 0;
    end
  end

  function automatic bit m_out();
    if (!m_run) return 1'b1;
    if (m_rmode >= 2) return (m_cnt != 1);
    return (m_cnt > m_rlen / 2);
  endfunction

  function automatic logic [7:0] m_rdata();
    if (!rd) return 8'h00;
    case (addr)
      3'd0: return {1'b0, m_flag, pf};
      3'd4: return 8'(m_cnt);
      3'd5: return {2'(m_rmode), 6'(m_cnt >> 8)};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk((m_run && m_rmode >= 2) ? "R7" : "R6", int'(tout), int'(m_out()));
      chk("R8", int'(tirq), int'(m_flag));
      chk((addr == 0) ? "R8" : ((addr == 4 || addr == 5) ? "R4" : "R9"),
          int'(rdata), int'(m_rdata()));
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; cyc(); wr = 1'b0; addr = '0;
  endtask

  task automatic wlen(input int l, input logic [1:0] m);
    wreg(3'd4, 8'(l));
    wreg(3'd5, {m, 6'(l >> 8)});
  endtask

  task automatic rchk(input logic [2:0] a, input int exp, input string req);
    addr = a; rd = 1'b1;
    @(negedge clk);
    chk(req, int'(rdata), exp);
    cyc(); rd = 1'b0; addr = '0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin tin = 1'b1; cyc(); tin = 1'b0; cyc(); end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    @(negedge clk);
    chk("R1", int'(tout), 1);
    chk("R1", int'(tirq), 0);
    cyc();
    rchk(3'd4, 0, "R1");
    rchk(3'd5, 0, "R1");
    rchk(3'd0, {2'b00, 6'h2A}, "R8");
    // R9 unassigned addresses
    rchk(3'd1, 0, "R9"); rchk(3'd2, 0, "R9"); rchk(3'd3, 0, "R9");
    rchk(3'd6, 0, "R9"); rchk(3'd7, 0, "R9");

    // single square wave, odd length 5 (R6, R5)
    wlen(5, 2'b00);
    wreg(3'd0, 8'h01);
    rchk(3'd4, 5, "R3");
    pulses(5);
    rchk(3'd4, 0, "R5");
    pf = 6'h15;
    rchk(3'd0, 8'h55, "R8");
    rchk(3'd0, 8'h15, "R8");

    // continuous square, length 4; rewrite mid-run (R2)
    wlen(4, 2'b01);
    wreg(3'd0, 8'h01);
    pulses(1);
    wlen(9, 2'b10);
    rchk(3'd4, 3, "R2");
    rchk(3'd5, 8'h40, "R2");
    // held level counts once (R4)
    tin = 1'b1; repeat (4) cyc(); tin = 1'b0; cyc();
    rchk(3'd4, 2, "R4");
    pulses(7);
    rchk(3'd0, {2'b01, 6'h15}, "R5");

    // single pulse mode, length 9 already written with mode 10 (R7)
    wreg(3'd0, 8'h01);
    pulses(10);
    rchk(3'd5, 8'h80, "R7");

    // continuous pulse, length 2, status reads mid-run (R7, R8)
    wlen(2, 2'b11);
    wreg(3'd0, 8'h01);
    pulses(3);
    rchk(3'd0, {2'b01, 6'h15}, "R8");
    pulses(4);
    rchk(3'd0, {2'b01, 6'h15}, "R8");

    // length 0 and 1 load as 2 (R3)
    wlen(0, 2'b00);
    wreg(3'd0, 8'h01);
    rchk(3'd4, 2, "R3");
    wlen(1, 2'b01);
    wreg(3'd0, 8'h01);
    rchk(3'd4, 2, "R3");
    rchk(3'd5, 8'h40, "R3");

    // stop wins over start and holds the count (R3)
    wlen(300, 2'b00);
    wreg(3'd0, 8'h01);
    pulses(2);
    wreg(3'd0, 8'h03);
    pulses(3);
    rchk(3'd4, 298 & 8'hFF, "R3");
    rchk(3'd5, 298 >> 8, "R3");
    @(negedge clk);
    chk("R7", int'(tout), 1);

    repeat (3) cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule